// File: doc/BRIEF.md
# Queue-Port Burst Subordinate

This block is an AXI4 subordinate that presents a hardware queue behind a single data-port address. Writing to the port pushes words into an internal first-in first-out store. Reading from the port pops them. A DMA engine moves a block of words with one same-address burst: every accepted write beat adds one entry at the tail, and every read beat removes one entry from the head. The block treats the port as an ordered queue. It is not a memory cell, so consecutive beats of a burst never overwrite each other.

Every incoming burst is screened before the block acts on it. The burst must be of the non-incrementing type, target the configured port word, use a beat size no wider than the bus, and stay within the sixteen-beat cap that applies to same-address bursts. A burst that fails the screen still completes on the bus, but the queue is left alone. This lets the block catch, for example, an incrementing burst that was aimed at the port by mistake. Write strobes are applied beat by beat. Each direction handles one burst at a time.

Top module: `axi_qport`

## Requirements
- R1: A write burst with AWBURST=2'b00 to the port word, with AWLEN at most 15 and AWSIZE at most 2, pushes AWLEN+1 words in beat order and answers OKAY (BRESP=2'b00); reads later return them in that order.
- R2: A read burst that passes the same checks returns ARLEN+1 beats, pops one entry per beat, answers RRESP=2'b00, and asserts RLAST on beat ARLEN and on no other beat.
- R3: Byte lane b of a word is stored, or returned on a read, only if WSTRB[b] is set (for writes) and (b >> AxSIZE) == (Ax address bits [1:0] >> AxSIZE). Every other lane is zero.
- R4: On a passing write burst, exactly AWLEN+1 beats are accepted. If WLAST is not set on beat AWLEN, or is set on any earlier beat, BRESP is SLVERR (2'b10). The beats are still pushed.
- R5: A burst with AxLEN above 15 or AxSIZE above 2 is rejected: the write drains its AWLEN+1 beats and returns SLVERR; the read returns ARLEN+1 SLVERR beats with zero data; the queue is unchanged.
- R6: A burst with AxBURST other than 2'b00, or with address bits [31:2] different from the port word (default 0x4000), leaves the queue unchanged. Its write beats are drained and answered with SLVERR, and every read beat carries SLVERR with zero data.
- R7: While the queue holds 16 entries, WREADY stays low on a passing burst until a pop frees space. No data is lost.
- R8: While the queue is empty, RVALID stays low on a passing read until a word is pushed.
- R9: BVALID rises only after the final W beat has been accepted. BID equals the burst's AWID and RID equals ARID. B and R outputs hold steady while stalled.
- R10: AWREADY is low from the AW handshake until the B handshake, and ARREADY is low from the AR handshake until the final R handshake.
- R11: After reset, AWREADY and ARREADY are high, BVALID and RVALID are low, and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| awid | input | 4 | Write burst ID |
| awaddr | input | 32 | Write address |
| awlen | input | 8 | Write beats minus one |
| awsize | input | 3 | Write beat size, log2 bytes |
| awburst | input | 2 | Write burst type |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Write byte strobes |
| wlast | input | 1 | Final write beat marker |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| bid | output | 4 | Response ID |
| bresp | output | 2 | Write response |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| arid | input | 4 | Read burst ID |
| araddr | input | 32 | Read address |
| arlen | input | 8 | Read beats minus one |
| arsize | input | 3 | Read beat size, log2 bytes |
| arburst | input | 2 | Read burst type |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| rid | output | 4 | Read ID |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response |
| rlast | output | 1 | Final read beat marker |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |

## Verification
The hold checks on B and R rely on the manager keeping BREADY and RREADY as plain handshakes. They also rely on the manager never withdrawing a valid it has raised. The bench meets this by raising each valid and keeping it up until the matching ready is sampled. The overflow and underflow properties rest on the queue head moving only on a pop, so the stimulus issues at most one write burst and one read burst at a time. It runs them concurrently only in the stall scenarios. All drive and sample points sit at the falling edge or just after the rising edge.

// File: rtl/axi_qport_pkg.sv
package axi_qport_pkg;
   localparam logic [1:0] BURST_SAME  = 2'b00;
   localparam logic [1:0] RESP_OKAY   = 2'b00;
   localparam logic [1:0] RESP_SLVERR = 2'b10;

   typedef enum logic [1:0] {
      WR_IDLE = 2'd0,
      WR_DATA = 2'd1,
      WR_RESP = 2'd2
   } wr_state_e;

   typedef enum logic {
      RD_IDLE = 1'b0,
      RD_DATA = 1'b1
   } rd_state_e;
endpackage

// File: rtl/qport_lanes.sv
module qport_lanes #(
   parameter int STRB_W = 4,
   localparam int LANE_AW = $clog2(STRB_W)
) (
   input  logic [LANE_AW-1:0] addr_lo,
   input  logic [2:0]         size,
   output logic [STRB_W-1:0]  lane_en,
   output logic               size_ok
);
   assign size_ok = ({29'd0, size} <= LANE_AW);

   for (genvar g = 0; g < STRB_W; g++) begin : g_lane
      assign lane_en[g] = ((LANE_AW'(g) >> size) == (addr_lo >> size));
   end
endmodule

// File: rtl/qport_fifo.sv
module qport_fifo #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 16,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic             full,
   output logic             empty,
   output logic [CNT_W-1:0] count
);
   localparam bit POW2 = ((1 << PTR_W) == DEPTH);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;

   if (POW2) begin : g_wrap_free
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   assign full  = (count == CNT_W'(DEPTH));
   assign empty = (count == '0);
   assign head  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/qport_wr.sv
module qport_wr
   import axi_qport_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int ID_W   = 4,
   parameter int MAX_LEN = 16,
   parameter logic [ADDR_W-1:0] PORT_ADDR = 'h4000,
   localparam int STRB_W  = DATA_W / 8,
   localparam int LANE_AW = $clog2(STRB_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ID_W-1:0]   awid,
   input  logic [ADDR_W-1:0] awaddr,
   input  logic [7:0]        awlen,
   input  logic [2:0]        awsize,
   input  logic [1:0]        awburst,
   input  logic              awvalid,
   output logic              awready,
   input  logic [DATA_W-1:0] wdata,
   input  logic [STRB_W-1:0] wstrb,
   input  logic              wlast,
   input  logic              wvalid,
   output logic              wready,
   output logic [ID_W-1:0]   bid,
   output logic [1:0]        bresp,
   output logic              bvalid,
   input  logic              bready,
   input  logic              q_full,
   output logic              push,
   output logic [DATA_W-1:0] push_data
);
   wr_state_e         st;
   logic [ID_W-1:0]   id_q;
   logic [7:0]        len_q, cnt_q;
   logic              ok_q, err_q;
   logic [STRB_W-1:0] lane_q, aw_lanes;
   logic [1:0]        bresp_q;
   logic              aw_size_ok, aw_ok, w_fire, last_beat, wlast_bad;

   qport_lanes #(.STRB_W(STRB_W)) u_lanes (
      .addr_lo (awaddr[LANE_AW-1:0]),
      .size    (awsize),
      .lane_en (aw_lanes),
      .size_ok (aw_size_ok)
   );

   assign aw_ok = (awburst == BURST_SAME)
               && (awaddr[ADDR_W-1:LANE_AW] == PORT_ADDR[ADDR_W-1:LANE_AW])
               && (awlen < 8'(MAX_LEN))
               && aw_size_ok;

   assign awready   = (st == WR_IDLE);
   assign wready    = (st == WR_DATA) && (!ok_q || !q_full);
   assign w_fire    = wvalid && wready;
   assign last_beat = (cnt_q == len_q);
   assign wlast_bad = (wlast != last_beat);
   assign push      = w_fire && ok_q;
   assign bvalid    = (st == WR_RESP);
   assign bid       = id_q;
   assign bresp     = bresp_q;

   for (genvar b = 0; b < STRB_W; b++) begin : g_byte
      assign push_data[8*b +: 8] = wdata[8*b +: 8] & {8{wstrb[b] & lane_q[b]}};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= WR_IDLE;
         id_q    <= '0;
         len_q   <= '0;
         cnt_q   <= '0;
         ok_q    <= 1'b0;
         err_q   <= 1'b0;
         lane_q  <= '0;
         bresp_q <= RESP_OKAY;
      end else begin
         case (st)
            WR_IDLE: if (awvalid) begin
               st     <= WR_DATA;
               id_q   <= awid;
               len_q  <= awlen;
               cnt_q  <= '0;
               ok_q   <= aw_ok;
               err_q  <= !aw_ok;
               lane_q <= aw_lanes;
            end
            WR_DATA: if (w_fire) begin
               cnt_q <= cnt_q + 8'd1;
               if (wlast_bad) err_q <= 1'b1;
               if (last_beat) begin
                  st      <= WR_RESP;
                  bresp_q <= (err_q || wlast_bad) ? RESP_SLVERR : RESP_OKAY;
               end
            end
            WR_RESP: if (bready) st <= WR_IDLE;
            default: st <= WR_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/qport_rd.sv
module qport_rd
   import axi_qport_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int ID_W   = 4,
   parameter int MAX_LEN = 16,
   parameter logic [ADDR_W-1:0] PORT_ADDR = 'h4000,
   localparam int STRB_W  = DATA_W / 8,
   localparam int LANE_AW = $clog2(STRB_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ID_W-1:0]   arid,
   input  logic [ADDR_W-1:0] araddr,
   input  logic [7:0]        arlen,
   input  logic [2:0]        arsize,
   input  logic [1:0]        arburst,
   input  logic              arvalid,
   output logic              arready,
   output logic [ID_W-1:0]   rid,
   output logic [DATA_W-1:0] rdata,
   output logic [1:0]        rresp,
   output logic              rlast,
   output logic              rvalid,
   input  logic              rready,
   input  logic              q_empty,
   input  logic [DATA_W-1:0] q_head,
   output logic              pop
);
   rd_state_e         st;
   logic [ID_W-1:0]   id_q;
   logic [7:0]        len_q, cnt_q;
   logic              ok_q;
   logic [STRB_W-1:0] lane_q, ar_lanes;
   logic              ar_size_ok, ar_ok, r_fire;

   qport_lanes #(.STRB_W(STRB_W)) u_lanes (
      .addr_lo (araddr[LANE_AW-1:0]),
      .size    (arsize),
      .lane_en (ar_lanes),
      .size_ok (ar_size_ok)
   );

   assign ar_ok = (arburst == BURST_SAME)
               && (araddr[ADDR_W-1:LANE_AW] == PORT_ADDR[ADDR_W-1:LANE_AW])
               && (arlen < 8'(MAX_LEN))
               && ar_size_ok;

   assign arready = (st == RD_IDLE);
   assign rvalid  = (st == RD_DATA) && (!ok_q || !q_empty);
   assign r_fire  = rvalid && rready;
   assign pop     = r_fire && ok_q;
   assign rlast   = (cnt_q == len_q);
   assign rresp   = ok_q ? RESP_OKAY : RESP_SLVERR;
   assign rid     = id_q;

   for (genvar b = 0; b < STRB_W; b++) begin : g_byte
      assign rdata[8*b +: 8] = q_head[8*b +: 8] & {8{ok_q & lane_q[b]}};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= RD_IDLE;
         id_q   <= '0;
         len_q  <= '0;
         cnt_q  <= '0;
         ok_q   <= 1'b0;
         lane_q <= '0;
      end else begin
         case (st)
            RD_IDLE: if (arvalid) begin
               st     <= RD_DATA;
               id_q   <= arid;
               len_q  <= arlen;
               cnt_q  <= '0;
               ok_q   <= ar_ok;
               lane_q <= ar_lanes;
            end
            RD_DATA: if (r_fire) begin
               cnt_q <= cnt_q + 8'd1;
               if (rlast) st <= RD_IDLE;
            end
            default: st <= RD_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/axi_qport.sv
module axi_qport #(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int ID_W    = 4,
   parameter int DEPTH   = 16,
   parameter int MAX_LEN = 16,
   parameter logic [ADDR_W-1:0] PORT_ADDR = 'h4000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ID_W-1:0]     awid,
   input  logic [ADDR_W-1:0]   awaddr,
   input  logic [7:0]          awlen,
   input  logic [2:0]          awsize,
   input  logic [1:0]          awburst,
   input  logic                awvalid,
   output logic                awready,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [DATA_W/8-1:0] wstrb,
   input  logic                wlast,
   input  logic                wvalid,
   output logic                wready,
   output logic [ID_W-1:0]     bid,
   output logic [1:0]          bresp,
   output logic                bvalid,
   input  logic                bready,
   input  logic [ID_W-1:0]     arid,
   input  logic [ADDR_W-1:0]   araddr,
   input  logic [7:0]          arlen,
   input  logic [2:0]          arsize,
   input  logic [1:0]          arburst,
   input  logic                arvalid,
   output logic                arready,
   output logic [ID_W-1:0]     rid,
   output logic [DATA_W-1:0]   rdata,
   output logic [1:0]          rresp,
   output logic                rlast,
   output logic                rvalid,
   input  logic                rready
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DATA_W < 16 || (DATA_W % 8) != 0 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data_w
      $error("axi_qport: DATA_W must be a power of two of at least 16");
   end
   if (MAX_LEN < 1 || MAX_LEN > 16) begin : g_bad_max_len
      $error("axi_qport: MAX_LEN must lie in 1..16 for same-address bursts");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("axi_qport: DEPTH must be at least 2");
   end
   if (ID_W < 1 || ID_W > 4) begin : g_bad_id_w
      $error("axi_qport: ID_W must lie in 1..4");
   end

   logic              fifo_push, fifo_pop, fifo_full, fifo_empty;
   logic [DATA_W-1:0] fifo_wdata, fifo_head;
   logic [CNT_W-1:0]  fifo_count;

   qport_wr #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W),
      .MAX_LEN(MAX_LEN), .PORT_ADDR(PORT_ADDR)
   ) u_wr (
      .clk(clk), .rst_n(rst_n),
      .awid(awid), .awaddr(awaddr), .awlen(awlen), .awsize(awsize),
      .awburst(awburst), .awvalid(awvalid), .awready(awready),
      .wdata(wdata), .wstrb(wstrb), .wlast(wlast), .wvalid(wvalid), .wready(wready),
      .bid(bid), .bresp(bresp), .bvalid(bvalid), .bready(bready),
      .q_full(fifo_full), .push(fifo_push), .push_data(fifo_wdata)
   );

   qport_rd #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W),
      .MAX_LEN(MAX_LEN), .PORT_ADDR(PORT_ADDR)
   ) u_rd (
      .clk(clk), .rst_n(rst_n),
      .arid(arid), .araddr(araddr), .arlen(arlen), .arsize(arsize),
      .arburst(arburst), .arvalid(arvalid), .arready(arready),
      .rid(rid), .rdata(rdata), .rresp(rresp), .rlast(rlast),
      .rvalid(rvalid), .rready(rready),
      .q_empty(fifo_empty), .q_head(fifo_head), .pop(fifo_pop)
   );

   qport_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(fifo_push), .push_data(fifo_wdata), .pop(fifo_pop),
      .head(fifo_head), .full(fifo_full), .empty(fifo_empty), .count(fifo_count)
   );
endmodule

// File: rtl/axi_qport_chk.sv
module axi_qport_chk #(
   parameter int DATA_W = 32,
   parameter int ID_W   = 4,
   parameter int DEPTH  = 16,
   parameter int CNT_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              awvalid,
   input logic              awready,
   input logic              arvalid,
   input logic              arready,
   input logic              wready,
   input logic              bvalid,
   input logic              bready,
   input logic [ID_W-1:0]   bid,
   input logic [1:0]        bresp,
   input logic              rvalid,
   input logic              rready,
   input logic [DATA_W-1:0] rdata,
   input logic [1:0]        rresp,
   input logic              rlast,
   input logic              fifo_push,
   input logic              fifo_pop,
   input logic [CNT_W-1:0]  fifo_count
);
   a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_push |-> (fifo_count != CNT_W'(DEPTH)) || fifo_pop);

   a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> (fifo_count != '0));

   a_r10_aw_single: assert property (@(posedge clk) disable iff (!rst_n)
      (awvalid && awready) |=> !awready);

   a_r10_ar_single: assert property (@(posedge clk) disable iff (!rst_n)
      (arvalid && arready) |=> !arready);

   a_r9_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (bvalid && !bready) |=> bvalid && $stable(bid) && $stable(bresp));

   a_r9_b_after_w: assert property (@(posedge clk) disable iff (!rst_n)
      bvalid |-> !wready);

   a_r2_r_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rvalid && !rready) |=> rvalid && $stable(rdata) && $stable(rlast) && $stable(rresp));

   a_r6_err_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (rvalid && rready && rresp == 2'b10) |-> !fifo_pop);
endmodule

bind axi_qport axi_qport_chk #(
   .DATA_W(DATA_W), .ID_W(ID_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) chk_i (
   .clk(clk), .rst_n(rst_n),
   .awvalid(awvalid), .awready(awready),
   .arvalid(arvalid), .arready(arready),
   .wready(wready),
   .bvalid(bvalid), .bready(bready), .bid(bid), .bresp(bresp),
   .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp), .rlast(rlast),
   .fifo_push(fifo_push), .fifo_pop(fifo_pop), .fifo_count(fifo_count)
);

// File: tb/axi_qport_tb_top.sv
module axi_qport_tb_top;
   localparam logic [31:0] PORT = 32'h4000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  awid = '0, arid = '0, bid, rid;
   logic [31:0] awaddr = '0, araddr = '0, wdata = '0, rdata;
   logic [7:0]  awlen = '0, arlen = '0;
   logic [2:0]  awsize = '0, arsize = '0;
   logic [1:0]  awburst = '0, arburst = '0, bresp, rresp;
   logic [3:0]  wstrb = '0;
   logic        awvalid = 0, awready, wlast = 0, wvalid = 0, wready;
   logic        bvalid, bready = 0, arvalid = 0, arready;
   logic        rlast, rvalid, rready = 0;

   int unsigned n_chk = 0, n_bad = 0;
   logic [31:0] model[$];
   logic [31:0] wbuf_d [0:31];
   logic [3:0]  wbuf_s [0:31];

   always #5 clk = ~clk;

   axi_qport dut_i (
      .clk(clk), .rst_n(rst_n),
      .awid(awid), .awaddr(awaddr), .awlen(awlen), .awsize(awsize), .awburst(awburst),
      .awvalid(awvalid), .awready(awready),
      .wdata(wdata), .wstrb(wstrb), .wlast(wlast), .wvalid(wvalid), .wready(wready),
      .bid(bid), .bresp(bresp), .bvalid(bvalid), .bready(bready),
      .arid(arid), .araddr(araddr), .arlen(arlen), .arsize(arsize), .arburst(arburst),
      .arvalid(arvalid), .arready(arready),
      .rid(rid), .rdata(rdata), .rresp(rresp), .rlast(rlast), .rvalid(rvalid), .rready(rready)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] lanes(input logic [31:0] d, input logic [3:0] s,
                                         input logic [1:0] lo, input logic [2:0] sz);
      logic [31:0] r = '0;
      for (int b = 0; b < 4; b++)
         if (s[b] && ((b >> sz) == (int'(lo) >> sz))) r[8*b +: 8] = d[8*b +: 8];
      return r;
   endfunction

   // Write burst: nbeats = len+1, wlast set on beat last_at (-1: never).
   task automatic do_write(input logic [3:0] id, input logic [31:0] addr, input int len,
                           input logic [2:0] sz, input logic [1:0] bt, input int last_at,
                           input bit good, input logic [1:0] exp_resp, input string req);
      @(negedge clk);
      awid = id; awaddr = addr; awlen = 8'(len); awsize = sz; awburst = bt; awvalid = 1;
      #1;
      while (!awready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      awvalid = 0;
      chk({req, " R10 awready low in burst"}, {31'd0, awready}, 32'd0);
      chk({req, " R9 no B before W"}, {31'd0, bvalid}, 32'd0);
      for (int i = 0; i <= len; i++) begin
         wdata = wbuf_d[i]; wstrb = wbuf_s[i]; wlast = (i == last_at); wvalid = 1;
         #1;
         while (!wready) begin @(negedge clk); #1; end
         @(posedge clk); #1;
         if (good) model.push_back(lanes(wbuf_d[i], wbuf_s[i], addr[1:0], sz));
      end
      wvalid = 0; wlast = 0;
      bready = 1;
      #1;
      while (!bvalid) begin @(negedge clk); #1; end
      chk({req, " R9 bid"}, {28'd0, bid}, {28'd0, id});
      chk({req, " bresp"}, {30'd0, bresp}, {30'd0, exp_resp});
      @(posedge clk); #1;
      bready = 0;
   endtask

   task automatic do_read(input logic [3:0] id, input logic [31:0] addr, input int len,
                          input logic [2:0] sz, input logic [1:0] bt,
                          input bit good, input string req);
      logic [31:0] e;
      @(negedge clk);
      arid = id; araddr = addr; arlen = 8'(len); arsize = sz; arburst = bt; arvalid = 1;
      #1;
      while (!arready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      arvalid = 0;
      chk({req, " R10 arready low in burst"}, {31'd0, arready}, 32'd0);
      for (int i = 0; i <= len; i++) begin
         rready = 1;
         #1;
         while (!rvalid) begin @(negedge clk); #1; end
         if (good) begin
            if (model.size() == 0) e = 32'hDEAD_BEEF;
            else e = lanes(model.pop_front(), 4'hF, addr[1:0], sz);
         end else e = '0;
         chk({req, " rdata"}, rdata, e);
         chk({req, " rresp"}, {30'd0, rresp}, good ? 32'd0 : 32'd2);
         chk({req, " R2 rlast"}, {31'd0, rlast}, {31'd0, (i == len)});
         chk({req, " R9 rid"}, {28'd0, rid}, {28'd0, id});
         @(posedge clk); #1;
      end
      rready = 0;
   endtask

   task automatic fill(input int n, input int seed);
      for (int i = 0; i < n; i++) begin
         wbuf_d[i] = 32'h9E37_79B9 * (i + 1) + 32'(seed) * 32'h0101_0101;
         wbuf_s[i] = 4'((i * 5 + seed) % 16);
      end
   endtask

   task automatic report;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      chk("R11 awready", {31'd0, awready}, 32'd1);
      chk("R11 arready", {31'd0, arready}, 32'd1);
      chk("R11 bvalid", {31'd0, bvalid}, 32'd0);
      chk("R11 rvalid", {31'd0, rvalid}, 32'd0);

      // R1 R2 R3: every legal length, varied strobes, ordered readback
      for (int len = 0; len < 16; len++) begin
         fill(len + 1, len);
         do_write(4'(len), PORT, len, 3'd2, 2'b00, len, 1, 2'b00, "R1 R3 write");
         do_read(4'(~len), PORT, len, 3'd2, 2'b00, 1, "R1 R2 read");
      end

      // R3: narrow beats pick lanes from address and size
      for (int sz = 0; sz < 3; sz++)
         for (int off = 0; off < 4; off += (1 << sz)) begin
            wbuf_d[0] = 32'hA1B2_C3D4; wbuf_s[0] = 4'hF;
            do_write(4'd3, PORT + 32'(off), 0, 3'(sz), 2'b00, 0, 1, 2'b00, "R3 narrow write");
            do_read(4'd3, PORT, 0, 3'd2, 2'b00, 1, "R3 narrow read");
         end
      wbuf_d[0] = 32'h1122_3344; wbuf_s[0] = 4'hF;
      do_write(4'd1, PORT, 0, 3'd2, 2'b00, 0, 1, 2'b00, "R3 setup");
      do_read(4'd1, PORT + 32'd2, 0, 3'd1, 2'b00, 1, "R3 narrow read lanes");

      // R4: WLAST early, then missing
      fill(4, 7);
      do_write(4'd5, PORT, 3, 3'd2, 2'b00, 1, 1, 2'b10, "R4 early wlast");
      do_read(4'd5, PORT, 3, 3'd2, 2'b00, 1, "R4 data kept");
      fill(3, 9);
      do_write(4'd6, PORT, 2, 3'd2, 2'b00, -1, 1, 2'b10, "R4 missing wlast");
      do_read(4'd6, PORT, 2, 3'd2, 2'b00, 1, "R4 data kept");

      // R5 R6: rejected bursts leave a marker word untouched
      wbuf_d[0] = 32'hC0DE_0001; wbuf_s[0] = 4'hF;
      do_write(4'd2, PORT, 0, 3'd2, 2'b00, 0, 1, 2'b00, "R5 marker");
      fill(17, 3);
      do_write(4'd7, PORT, 16, 3'd2, 2'b00, 16, 0, 2'b10, "R5 len 17 write");
      fill(1, 4);
      do_write(4'd8, PORT, 0, 3'd3, 2'b00, 0, 0, 2'b10, "R5 wide size write");
      fill(4, 5);
      do_write(4'd9, PORT, 3, 3'd2, 2'b01, 3, 0, 2'b10, "R6 incr write");
      fill(2, 6);
      do_write(4'd10, 32'h5000, 1, 3'd2, 2'b00, 1, 0, 2'b10, "R6 wrong addr write");
      do_read(4'd11, PORT, 16, 3'd2, 2'b00, 0, "R5 len 17 read");
      do_read(4'd12, PORT, 2, 3'd2, 2'b01, 0, "R6 incr read");
      do_read(4'd13, 32'h4004, 0, 3'd2, 2'b00, 0, "R6 wrong addr read");
      do_read(4'd14, PORT, 0, 3'd2, 2'b00, 1, "R5 R6 marker intact");

      // R7: full queue stalls WREADY until a pop
      fill(16, 11);
      do_write(4'd1, PORT, 15, 3'd2, 2'b00, 15, 1, 2'b00, "R7 fill");
      fork
         begin
            wbuf_d[0] = 32'hFEED_0017; wbuf_s[0] = 4'hF;
            do_write(4'd2, PORT, 0, 3'd2, 2'b00, 0, 1, 2'b00, "R7 extra");
         end
         begin
            repeat (6) begin
               @(negedge clk); #1;
               chk("R7 wready low when full", {31'd0, wready}, 32'd0);
            end
            do_read(4'd3, PORT, 0, 3'd2, 2'b00, 1, "R7 pop one");
         end
      join
      do_read(4'd4, PORT, 15, 3'd2, 2'b00, 1, "R7 drain order");

      // R8: empty queue stalls RVALID until a push
      fork
         do_read(4'd5, PORT, 0, 3'd2, 2'b00, 1, "R8 wait read");
         begin
            repeat (6) begin
               @(negedge clk); #1;
               chk("R8 rvalid low when empty", {31'd0, rvalid}, 32'd0);
            end
            wbuf_d[0] = 32'h0BAD_F00D; wbuf_s[0] = 4'hF;
            do_write(4'd6, PORT, 0, 3'd2, 2'b00, 0, 1, 2'b00, "R8 late push");
         end
      join
      chk("R1 queue drained", model.size(), 32'd0);

      repeat (3) @(posedge clk);
      report();
   end
endmodule